// File: doc/BRIEF.md
# Three-Operand ALU With Status Flags

This block is the integer execution unit of a simple datapath. Each cycle it takes two source operands and an operation code and produces a result combinationally. The result sets the operand role: A is the first source and B is the second. Arithmetic and shift operations apply A to B: B plus A, B minus A, and B shifted by A. Beside the result, the block keeps a 4-bit status word with zero, negative, carry and overflow flags.

The status word is a register. When `op_valid` is high at a rising clock edge, it takes the flags that the current operation produces. When `op_valid` is low, it holds its value. The carry-chained add and the borrow-chained subtract read the stored carry as their carry-in or borrow-in. They also AND their zero result with the stored zero flag. Because of this, a multi-word sum or difference reports zero only when every word was zero. Register addressing, memory access and multiplication are handled outside the block.

Top module: `tri_alu`

## Requirements
- R1: Operation code 0 (add) gives result B+A modulo 2^32. C becomes the carry out of bit 31. V is set when A and B have the same sign and the result sign differs from it. Z is set when the result is zero.
- R2: Operation code 1 (add with carry) gives B+A+C, where C is the stored carry. The new C is the carry out of that sum and V follows the rule of R1. The new Z is the old Z ANDed with (result == 0).
- R3: Operation code 2 (subtract) gives B-A. C is set when A > B as unsigned values. V is set when A and B have different signs and the result sign differs from the sign of B. Z is set when the result is zero.
- R4: Operation code 3 (subtract with borrow) gives B-A-C. C is set when A > B as unsigned values and V follows the rule of R3. The new Z is the old Z ANDed with (result == 0).
- R5: Operation codes 4, 5 and 6 give B AND A, B OR A and B XOR A. Each of them sets Z from the result and clears both C and V.
- R6: Operation code 7 shifts B right arithmetically by A, code 8 shifts B right logically by A, and code 9 shifts B left by A. A is read as a full unsigned 32-bit amount. An amount of 32 or more gives 0 for codes 8 and 9 and gives 32 copies of B[31] for code 7.
- R7: The shift operations (codes 7, 8, 9) set Z from the result, clear C and leave V unchanged.
- R8: For every defined operation (codes 0 to 9), the new N equals bit 31 of the result. The status word is packed as status[0]=Z, status[1]=N, status[2]=C, status[3]=V.
- R9: The status word changes only at a rising clock edge where op_valid is high. With op_valid low it holds its value, while the result output still follows the inputs.
- R10: An asynchronous active-low reset clears the status word to 0. Operation codes 10 to 15 give result 0 and leave the status word unchanged even when op_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the status word updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the status word |
| op_valid | input | 1 | Commits the current operation's flags at the next edge |
| op_code | input | 4 | Operation select, codes 0 to 9 defined |
| src_a | input | 32 | Operand A: the subtrahend, addend or shift amount |
| src_b | input | 32 | Operand B: the minuend, augend or shifted value |
| result | output | 32 | Combinational result of the selected operation |
| status | output | 4 | Registered flags {V, C, N, Z} |

## Verification
Two things can fall in the same cycle: a chained operation and the status update it depends on. An add-with-carry or subtract-with-borrow reads the C and Z that the previous operation wrote at the edge just before. The bench provokes this by issuing chained operations back to back with op_valid high, including runs where op_valid drops between them. It judges each result against a reference model's carried flags, so a stale or early flag read shows up as a wrong result or a wrong Z on the very next sample.

// File: rtl/talu_pkg.sv
package talu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADDC = 4'd1,
    OP_SUB  = 4'd2,
    OP_SUBB = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_ASR  = 4'd7,
    OP_LSR  = 4'd8,
    OP_LSL  = 4'd9
  } talu_op_e;

  // status[0]=z, status[1]=n, status[2]=c, status[3]=v
  typedef struct packed {
    logic v;
    logic c;
    logic n;
    logic z;
  } talu_flags_t;

  function automatic logic op_known(talu_op_e op);
    return op inside {OP_ADD, OP_ADDC, OP_SUB, OP_SUBB, OP_AND, OP_OR,
                      OP_XOR, OP_ASR, OP_LSR, OP_LSL};
  endfunction

  function automatic logic op_is_arith(talu_op_e op);
    return op inside {OP_ADD, OP_ADDC, OP_SUB, OP_SUBB};
  endfunction

  function automatic logic op_is_logic(talu_op_e op);
    return op inside {OP_AND, OP_OR, OP_XOR};
  endfunction

  function automatic logic op_is_shift(talu_op_e op);
    return op inside {OP_ASR, OP_LSR, OP_LSL};
  endfunction

  function automatic logic op_is_sub(talu_op_e op);
    return op inside {OP_SUB, OP_SUBB};
  endfunction

  // chained operations: consume stored carry and AND into stored zero
  function automatic logic op_chains(talu_op_e op);
    return op inside {OP_ADDC, OP_SUBB};
  endfunction

endpackage

// File: rtl/talu_addsub.sv
module talu_addsub #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             sub,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             carry_flag,
  output logic             ovf
);
  localparam int MSB = WIDTH - 1;

  function automatic logic [WIDTH:0] wide_add(logic [WIDTH-1:0] x,
                                              logic [WIDTH-1:0] y,
                                              logic ci);
    return {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, ci};
  endfunction

  function automatic logic add_overflow(logic sa, logic sb, logic sr);
    return (sa == sb) && (sr != sa);
  endfunction

  function automatic logic sub_overflow(logic sa, logic sb, logic sr);
    return (sa != sb) && (sr != sb);
  endfunction

  logic [WIDTH-1:0] a_eff;
  logic             ci_eff;
  logic [WIDTH:0]   ext;
  logic             a_above_b;

  // subtraction: b + ~a + 1 - borrow
  assign a_eff     = sub ? ~a : a;
  assign ci_eff    = sub ? ~cin : cin;
  assign ext       = wide_add(b, a_eff, ci_eff);
  assign sum       = ext[WIDTH-1:0];
  assign a_above_b = (a > b);

  assign carry_flag = sub ? a_above_b : ext[WIDTH];
  assign ovf        = sub ? sub_overflow(a[MSB], b[MSB], sum[MSB])
                          : add_overflow(a[MSB], b[MSB], sum[MSB]);
endmodule

// File: rtl/talu_logic.sv
module talu_logic #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [1:0]       sel,
  output logic [WIDTH-1:0] out
);
  always_comb begin
    unique case (sel)
      2'd0:    out = b & a;
      2'd1:    out = b | a;
      2'd2:    out = b ^ a;
      default: out = '0;
    endcase
  end
endmodule

// File: rtl/talu_shift.sv
module talu_shift #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] val,
  input  logic [WIDTH-1:0] amt,
  input  logic             right,
  input  logic             arith,
  output logic [WIDTH-1:0] out
);
  localparam int MSB = WIDTH - 1;
  localparam int SHW = $clog2(WIDTH);
  localparam logic [WIDTH-1:0] LIMIT = WIDTH'(WIDTH);

  logic             fill;
  logic             amt_big;
  logic [WIDTH-1:0] rs;
  logic [WIDTH-1:0] ls;

  assign fill    = arith & val[MSB];
  assign amt_big = (amt >= LIMIT);

  // log-depth barrel: stage k moves by 2^k when amount bit k is set
  always_comb begin
    rs = val;
    ls = val;
    for (int k = 0; k < SHW; k++) begin
      if (amt[k]) begin
        rs = (rs >> (1 << k)) | (fill ? ~({WIDTH{1'b1}} >> (1 << k)) : '0);
        ls = ls << (1 << k);
      end
    end
  end

  always_comb begin
    if (right) out = amt_big ? {WIDTH{fill}} : rs;
    else       out = amt_big ? '0 : ls;
  end
endmodule

// File: rtl/talu_status.sv
module talu_status
  import talu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  talu_op_e         op,
  input  logic [WIDTH-1:0] res,
  input  logic             arith_c,
  input  logic             arith_v,
  output talu_flags_t      flags
);
  talu_flags_t nxt;
  logic        res_zero;

  assign res_zero = (res == '0);

  always_comb begin
    nxt = flags;
    if (op_known(op)) begin
      nxt.n = res[WIDTH-1];
      nxt.z = op_chains(op) ? (flags.z & res_zero) : res_zero;
      if (op_is_arith(op)) begin
        nxt.c = arith_c;
        nxt.v = arith_v;
      end else if (op_is_logic(op)) begin
        nxt.c = 1'b0;
        nxt.v = 1'b0;
      end else begin
        nxt.c = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flags <= '0;
    else if (op_valid) flags <= nxt;
  end
endmodule

// File: rtl/tri_alu.sv
module tri_alu
  import talu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [3:0]       op_code,
  input  logic [WIDTH-1:0] src_a,
  input  logic [WIDTH-1:0] src_b,
  output logic [WIDTH-1:0] result,
  output logic [3:0]       status
);
  talu_op_e         op;
  talu_flags_t      flags;
  logic             as_sub;
  logic             as_cin;
  logic [WIDTH-1:0] as_sum;
  logic             as_carry;
  logic             as_ovf;
  logic [1:0]       lg_sel;
  logic [WIDTH-1:0] lg_out;
  logic             sh_right;
  logic             sh_arith;
  logic [WIDTH-1:0] sh_out;

  assign op       = talu_op_e'(op_code);
  assign as_sub   = op_is_sub(op);
  assign as_cin   = op_chains(op) & flags.c;
  assign lg_sel   = (op == OP_AND) ? 2'd0 : (op == OP_OR) ? 2'd1 : 2'd2;
  assign sh_right = (op != OP_LSL);
  assign sh_arith = (op == OP_ASR);

  talu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a(src_a), .b(src_b), .sub(as_sub), .cin(as_cin),
    .sum(as_sum), .carry_flag(as_carry), .ovf(as_ovf)
  );

  talu_logic #(.WIDTH(WIDTH)) u_logic (
    .a(src_a), .b(src_b), .sel(lg_sel), .out(lg_out)
  );

  talu_shift #(.WIDTH(WIDTH)) u_shift (
    .val(src_b), .amt(src_a), .right(sh_right), .arith(sh_arith), .out(sh_out)
  );

  always_comb begin
    if (op_is_arith(op))      result = as_sum;
    else if (op_is_logic(op)) result = lg_out;
    else if (op_is_shift(op)) result = sh_out;
    else                      result = '0;
  end

  talu_status #(.WIDTH(WIDTH)) u_status (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op(op), .res(result),
    .arith_c(as_carry), .arith_v(as_ovf), .flags(flags)
  );

  assign status = flags;
endmodule

// File: rtl/talu_checker.sv
module talu_checker #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             op_valid,
  input logic [3:0]       op_code,
  input logic [WIDTH-1:0] src_a,
  input logic [WIDTH-1:0] src_b,
  input logic [WIDTH-1:0] result,
  input logic [3:0]       status,
  input logic             as_carry,
  input logic             as_ovf
);
  p_add_carry_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 4'd0) |=> status[2] == ($past(result) < $past(src_a)));

  p_add_ovf_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 4'd0) |=> status[3] == $past(as_ovf));

  p_chain_carry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 4'd1) |=> status[2] == $past(as_carry));

  p_chain_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_code == 4'd1 || op_code == 4'd3) && !status[0]) |=> !status[0]);

  p_sub_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_code == 4'd2 || op_code == 4'd3))
      |=> status[2] == ($past(src_a) > $past(src_b)));

  p_logic_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code >= 4'd4 && op_code <= 4'd6) |=> (status[3:2] == 2'b00));

  p_shift_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code >= 4'd7 && op_code <= 4'd9)
      |=> (!status[2] && status[3] == $past(status[3])));

  p_sign_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code <= 4'd9) |=> status[1] == $past(result[WIDTH-1]));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(status));

  p_undef_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code > 4'd9) |=> $stable(status));

  p_undef_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code > 4'd9) |-> result == '0);
endmodule

bind tri_alu talu_checker #(.WIDTH(WIDTH)) u_talu_checker (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
  .src_a(src_a), .src_b(src_b), .result(result), .status(status),
  .as_carry(as_carry), .as_ovf(as_ovf)
);

// File: tb/tri_alu_bench.sv
module tri_alu_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [3:0]  op_code;
  logic [31:0] src_a;
  logic [31:0] src_b;
  logic [31:0] result;
  logic [3:0]  status;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;
  // reference flags
  bit  mz = 0, mn = 0, mc = 0, mv = 0;

  always #2 clk = ~clk;

  tri_alu u_tri_alu (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .src_a(src_a), .src_b(src_b), .result(result), .status(status)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string op_tag(int op);
    case (op)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4, 5, 6: return "R5";
      7, 8, 9: return "R6";
      default: return "R10";
    endcase
  endfunction

  task automatic step(int op, logic [31:0] a, logic [31:0] b, bit v);
    logic [32:0] w;
    logic [31:0] er;
    longint      sr;
    bit nz, nn, nc, nv;
    string stag;
    @(negedge clk);
    op_valid = v; op_code = 4'(op); src_a = a; src_b = b;
    #1;
    nz = mz; nn = mn; nc = mc; nv = mv;
    er = '0;
    case (op)
      0: begin
        w  = {1'b0, b} + {1'b0, a};
        er = w[31:0]; nc = w[32];
        sr = longint'($signed(b)) + longint'($signed(a));
        nv = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
        nz = (er == 0);
      end
      1: begin
        w  = {1'b0, b} + {1'b0, a} + 33'(mc);
        er = w[31:0]; nc = w[32];
        sr = longint'($signed(b)) + longint'($signed(a)) + longint'(mc);
        nv = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
        nz = mz && (er == 0);
      end
      2: begin
        er = b - a; nc = (a > b);
        sr = longint'($signed(b)) - longint'($signed(a));
        nv = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
        nz = (er == 0);
      end
      3: begin
        er = b - a - 32'(mc); nc = (a > b);
        sr = longint'($signed(b)) - longint'($signed(a)) - longint'(mc);
        nv = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
        nz = mz && (er == 0);
      end
      4: begin er = b & a; nc = 0; nv = 0; nz = (er == 0); end
      5: begin er = b | a; nc = 0; nv = 0; nz = (er == 0); end
      6: begin er = b ^ a; nc = 0; nv = 0; nz = (er == 0); end
      7: begin er = $signed(b) >>> a; nc = 0; nz = (er == 0); end
      8: begin er = b >> a; nc = 0; nz = (er == 0); end
      9: begin er = b << a; nc = 0; nz = (er == 0); end
      default: er = '0;
    endcase
    if (op <= 9) nn = er[31];
    check(op_tag(op), result, er);
    @(posedge clk);
    #1;
    if (v) begin mz = nz; mn = nn; mc = nc; mv = nv; end
    if (!v)          stag = "R9";
    else if (op > 9) stag = "R10";
    else if (op >= 7) stag = "R7";
    else             stag = {"R8 ", op_tag(op)};
    check(stag, {28'd0, status}, {28'd0, mv, mc, mn, mz});
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL R9 watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; op_code = '0; src_a = '0; src_b = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R10: reset state
    check("R10", {28'd0, status}, 32'd0);

    // R1: wrap to zero with carry, then signed overflow
    step(0, 32'h0000_0001, 32'hFFFF_FFFF, 1);
    step(0, 32'h0000_0001, 32'h7FFF_FFFF, 1);
    // R2: chained add with Z set and C set from a carry-out
    step(0, 32'h0000_0001, 32'hFFFF_FFFF, 1);
    step(1, 32'h0000_0000, 32'hFFFF_FFFF, 1);
    // R2: old Z clear, zero result keeps Z clear
    step(0, 32'h0000_0001, 32'h0000_0001, 1);
    step(1, 32'h0000_0000, 32'h0000_0000, 1);
    // R3: equal, borrow, signed overflow
    step(2, 32'h1234_5678, 32'h1234_5678, 1);
    step(2, 32'h0000_0005, 32'h0000_0003, 1);
    step(2, 32'h0000_0001, 32'h8000_0000, 1);
    // R4: borrow chain
    step(2, 32'h0000_0001, 32'h0000_0000, 1);
    step(3, 32'h0000_0000, 32'h0000_0001, 1);
    step(3, 32'h0000_0000, 32'h8000_0000, 1);
    // R5: logic ops after C and V are set
    step(0, 32'h8000_0000, 32'h8000_0000, 1);
    step(4, 32'hF0F0_F0F0, 32'h0F0F_0F0F, 1);
    step(5, 32'h8000_0000, 32'h0000_0001, 1);
    step(6, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1);
    // R6 and R7: shifts at boundary amounts, V kept after set
    step(0, 32'h0000_0001, 32'h7FFF_FFFF, 1);
    step(7, 32'd4, 32'h8000_0010, 1);
    step(7, 32'd31, 32'h8000_0000, 1);
    step(7, 32'd32, 32'h8000_0000, 1);
    step(7, 32'd100, 32'h7000_0000, 1);
    step(8, 32'd0, 32'h8000_0001, 1);
    step(8, 32'd31, 32'h8000_0000, 1);
    step(8, 32'd32, 32'hFFFF_FFFF, 1);
    step(9, 32'd1, 32'h8000_0001, 1);
    step(9, 32'd31, 32'h0000_0001, 1);
    step(9, 32'hFFFF_FFFF, 32'h0000_0001, 1);
    // R9: op_valid low holds status while result tracks inputs
    step(0, 32'h0000_0001, 32'hFFFF_FFFF, 0);
    step(2, 32'h0000_0009, 32'h0000_0001, 0);
    // R10: undefined codes
    step(12, 32'h1, 32'h2, 1);
    step(15, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1);

    // mixed back-to-back sequence including chained operations
    for (int i = 0; i < 4000; i++) begin
      int          op;
      logic [31:0] a;
      logic [31:0] b;
      bit          v;
      op = int'($urandom_range(0, 11));
      a  = $urandom;
      b  = $urandom;
      case ($urandom_range(0, 5))
        0: a = 32'(($urandom_range(0, 40)));
        1: b = a;
        2: a = '0;
        3: b = 32'hFFFF_FFFF;
        default: ;
      endcase
      if (op >= 7 && op <= 9 && $urandom_range(0, 1) == 1) a = 32'($urandom_range(0, 35));
      v = ($urandom_range(0, 7) != 0);
      step(op, a, b, v);
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule